// File: doc/BRIEF.md
# Sign-Extending Per-Byte Bounds Checker

This block decides whether a memory access is allowed by an authorising capability. An access is a load, store or instruction fetch of 1, 2, 4 or 8 bytes. Loads, stores and fetches all go through the same check. The bounds arrive already decoded as a base, an exclusive top and a flag that marks the bounds as unlimited. The core may run with an effective address width narrower than the full register width. In that narrow mode, the block works out each byte's address at the narrow width. It then sign-extends that address to the full width and compares it with the bounds. Each byte is checked on its own.

In narrow mode, an access that steps across the midpoint of the narrow address space is refused. An access that wraps from the top of the narrow space back to zero is also refused. Both refusals hold even when every extended byte address lies inside the bounds, unless the bounds are unlimited. The verdict is registered. It reports a pass flag, a cause code and the index of the lowest failing byte, one cycle after the request.

Top module: `sign_ext_bounds_check`

## Requirements
- R1: A byte passes when base <= extended byte address < top, with top a full-width-plus-one value. An access passes only when every one of its bytes passes.
- R2: With `narrow_mode` = 1, byte i's address is (req_addr + i) mod 2^NARROW_W, sign-extended from bit NARROW_W-1. The upper bits of `req_addr` have no effect.
- R3: With `narrow_mode` = 0, byte i's address is (req_addr + i) mod 2^MAX_W, with no extension. Crossing 2^(NARROW_W-1) is then not a fault.
- R4: In narrow mode, a byte whose narrow address has a different top bit (bit NARROW_W-1) from byte 0 fails when it lies past the 2^(NARROW_W-1) midpoint. This holds even if the byte is inside the bounds.
- R5: In narrow mode, an access wrapping from 2^NARROW_W to 0 fails from the first wrapped byte on, even if that byte is inside the bounds.
- R6: When `cap_infinite` is 1, every access passes, including those that cross the midpoint or wrap.
- R7: A failing access gives rsp_pass=0, rsp_cause=1 (length violation) and rsp_fail_idx equal to the lowest failing byte index. A passing access gives rsp_cause=0 and rsp_fail_idx=0.
- R8: `req_size` encodes the length as 1 << req_size bytes (0:1, 1:2, 2:4, 3:8). Bytes beyond the length are not checked.
- R9: The result appears on the clock edge after the request. rsp_valid equals the previous cycle's req_valid. After reset, rsp_valid, rsp_pass, rsp_cause and rsp_fail_idx are all 0.
- R10: With cap_top <= cap_base and no unlimited bounds, every access fails at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| narrow_mode | input | 1 | 1: effective width NARROW_W, 0: full MAX_W |
| req_addr | input | MAX_W | Start address of the access |
| req_size | input | 2 | log2 of the access length in bytes |
| cap_base | input | MAX_W | Decoded lower bound (inclusive) |
| cap_top | input | MAX_W+1 | Decoded upper bound (exclusive) |
| cap_infinite | input | 1 | Bounds cover the whole space |
| rsp_valid | output | 1 | Verdict present |
| rsp_pass | output | 1 | Access allowed |
| rsp_cause | output | 2 | 0 none, 1 length violation |
| rsp_fail_idx | output | 3 | Lowest failing byte index |

## Verification
The access path is tried with accesses that lie fully inside the bounds, accesses that run off either end, and accesses whose length alone decides the verdict. Together these separate the comparison from the length decoding. Midpoint-crossing and wrapping accesses are run under bounds that contain every extended byte, in both width modes and with and without unlimited bounds. This separates the span rule from the plain comparison and from the width selection. Addresses with garbage upper bits in narrow mode show that the truncation and sign extension happen before the comparison, and a full-width wrap shows the wide path.

// File: rtl/bchk_pkg.sv
// Package: shared cause codes for the bounds checker.
// Assumes: cause field is two bits wide.
package bchk_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_LENGTH = 2'd1
    } cause_e;
endpackage

// File: rtl/bchk_lane_addr.sv
// Module: bchk_lane_addr
// Forms the address of every byte lane of an access at the selected
// effective width, sign-extends it to the full width, and flags lanes
// whose narrow top bit differs from lane 0 (midpoint crossing or wrap).
// Assumes: NARROW_W < MAX_W and LANES is small (a few bytes).
module bchk_lane_addr #(
    parameter int MAX_W    = 64,
    parameter int NARROW_W = 32,
    parameter int LANES    = 8
) (
    input  logic                        narrow_mode,
    input  logic [MAX_W-1:0]            req_addr,
    output logic [LANES-1:0][MAX_W-1:0] lane_addr,
    output logic [LANES-1:0]            lane_cross
);
    localparam int EXT_W = MAX_W - NARROW_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [MAX_W-1:0]    sum;
        logic [NARROW_W-1:0] low;

        // Per-lane address: add the lane offset, then pick width variant.
        always_comb begin
            sum = req_addr + MAX_W'(g);
            low = sum[NARROW_W-1:0];
            if (narrow_mode) begin
                lane_addr[g]  = {{EXT_W{low[NARROW_W-1]}}, low};
                lane_cross[g] = (low[NARROW_W-1] != req_addr[NARROW_W-1]);
            end else begin
                lane_addr[g]  = sum;
                lane_cross[g] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/bchk_lane_cmp.sv
// Module: bchk_lane_cmp
// Compares each active lane address with the bounds and folds in the
// span rule; unlimited bounds clear every lane failure.
// Assumes: top is one bit wider than base so 2^MAX_W is expressible.
module bchk_lane_cmp #(
    parameter int MAX_W = 64,
    parameter int LANES = 8
) (
    input  logic [LANES-1:0][MAX_W-1:0] lane_addr,
    input  logic [LANES-1:0]            lane_cross,
    input  logic [LANES-1:0]            lane_active,
    input  logic [MAX_W-1:0]            cap_base,
    input  logic [MAX_W:0]              cap_top,
    input  logic                        cap_infinite,
    output logic [LANES-1:0]            lane_fail
);
    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        logic below, above;

        // Lane verdict: out of bounds or span violation, when checked.
        always_comb begin
            below        = (lane_addr[g] < cap_base);
            above        = ({1'b0, lane_addr[g]} >= cap_top);
            lane_fail[g] = lane_active[g] && !cap_infinite
                           && (below || above || lane_cross[g]);
        end
    end
endmodule

// File: rtl/bchk_first_fail.sv
// Module: bchk_first_fail
// Finds whether any lane failed and the index of the lowest one.
// Assumes: IDX_W is wide enough to index every lane.
module bchk_first_fail #(
    parameter int LANES = 8,
    parameter int IDX_W = 3
) (
    input  logic [LANES-1:0] lane_fail,
    output logic             any_fail,
    output logic [IDX_W-1:0] first_idx
);
    // Priority scan from the top lane down so the lowest index wins.
    always_comb begin
        any_fail  = |lane_fail;
        first_idx = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (lane_fail[i]) first_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/sign_ext_bounds_check.sv
// Module: sign_ext_bounds_check (top)
// Checks a 1..LANES byte access against decoded capability bounds,
// per byte, after narrow-to-wide sign extension; registers the verdict.
// Assumes: LANES is a power of two and req_size selects 1 << req_size bytes.
module sign_ext_bounds_check #(
    parameter int MAX_W    = 64,
    parameter int NARROW_W = 32,
    parameter int LANES    = 8,
    localparam int IDX_W   = $clog2(LANES),
    localparam int SIZE_W  = $clog2(IDX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              narrow_mode,
    input  logic [MAX_W-1:0]  req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [MAX_W-1:0]  cap_base,
    input  logic [MAX_W:0]    cap_top,
    input  logic              cap_infinite,
    output logic              rsp_valid,
    output logic              rsp_pass,
    output logic [1:0]        rsp_cause,
    output logic [IDX_W-1:0]  rsp_fail_idx
);
    import bchk_pkg::*;

    logic [LANES-1:0][MAX_W-1:0] lane_addr;
    logic [LANES-1:0]            lane_cross;
    logic [LANES-1:0]            lane_active;
    logic [LANES-1:0]            lane_fail;
    logic                        any_fail;
    logic [IDX_W-1:0]            first_idx;

    // Lane enable: lane g is part of the access when g < 1 << req_size.
    always_comb begin
        for (int g = 0; g < LANES; g++) begin
            lane_active[g] = ((IDX_W + 1)'(g) < ((IDX_W + 1)'(1) << req_size));
        end
    end

    bchk_lane_addr #(.MAX_W(MAX_W), .NARROW_W(NARROW_W), .LANES(LANES)) u_addr (
        .narrow_mode (narrow_mode),
        .req_addr    (req_addr),
        .lane_addr   (lane_addr),
        .lane_cross  (lane_cross)
    );

    bchk_lane_cmp #(.MAX_W(MAX_W), .LANES(LANES)) u_cmp (
        .lane_addr    (lane_addr),
        .lane_cross   (lane_cross),
        .lane_active  (lane_active),
        .cap_base     (cap_base),
        .cap_top      (cap_top),
        .cap_infinite (cap_infinite),
        .lane_fail    (lane_fail)
    );

    bchk_first_fail #(.LANES(LANES), .IDX_W(IDX_W)) u_first (
        .lane_fail (lane_fail),
        .any_fail  (any_fail),
        .first_idx (first_idx)
    );

    // Output stage: capture the verdict of a valid request for timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_pass     <= 1'b0;
            rsp_cause    <= CAUSE_NONE;
            rsp_fail_idx <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pass     <= !any_fail;
                rsp_cause    <= any_fail ? CAUSE_LENGTH : CAUSE_NONE;
                rsp_fail_idx <= any_fail ? first_idx : '0;
            end
        end
    end
endmodule

// File: rtl/bchk_checker.sv
// Module: bchk_checker
// Temporal properties of the bounds checker ports, bound to the top.
// Assumes: port names match the top module so .* binding connects them.
module bchk_checker #(
    parameter int MAX_W    = 64,
    parameter int NARROW_W = 32,
    parameter int LANES    = 8,
    localparam int IDX_W   = $clog2(LANES),
    localparam int SIZE_W  = $clog2(IDX_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [SIZE_W-1:0] req_size,
    input logic [MAX_W-1:0]  cap_base,
    input logic [MAX_W:0]    cap_top,
    input logic              cap_infinite,
    input logic              rsp_valid,
    input logic              rsp_pass,
    input logic [1:0]        rsp_cause,
    input logic [IDX_W-1:0]  rsp_fail_idx
);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_pass_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_pass) |-> (rsp_cause == 2'd0 && rsp_fail_idx == '0));

    assert_fail_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_pass) |-> (rsp_cause == 2'd1));

    assert_infinite_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cap_infinite) |=> rsp_pass);

    assert_empty_fails_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !cap_infinite && cap_top <= {1'b0, cap_base}) |=> !rsp_pass);

    assert_idx_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_pass || (32'(rsp_fail_idx) < (32'd1 << $past(req_size)))));
endmodule

bind sign_ext_bounds_check bchk_checker #(
    .MAX_W(MAX_W), .NARROW_W(NARROW_W), .LANES(LANES)
) u_bchk_checker (.*);

// File: tb/tb_sign_ext_bounds_check.sv
module tb_sign_ext_bounds_check;
    localparam int MAX_W = 64;
    localparam int NARROW_W = 32;
    localparam int LANES = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              narrow_mode = 1'b0;
    logic [MAX_W-1:0]  req_addr = '0;
    logic [1:0]        req_size = '0;
    logic [MAX_W-1:0]  cap_base = '0;
    logic [MAX_W:0]    cap_top = '0;
    logic              cap_infinite = 1'b0;
    logic              rsp_valid, rsp_pass;
    logic [1:0]        rsp_cause;
    logic [2:0]        rsp_fail_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sign_ext_bounds_check #(.MAX_W(MAX_W), .NARROW_W(NARROW_W), .LANES(LANES)) dut (
        .clk, .rst_n, .req_valid, .narrow_mode, .req_addr, .req_size,
        .cap_base, .cap_top, .cap_infinite,
        .rsp_valid, .rsp_pass, .rsp_cause, .rsp_fail_idx
    );

    typedef struct packed {
        logic        nm;
        logic [63:0] addr;
        logic [1:0]  size;
        logic [63:0] base;
        logic [64:0] top;
        logic        inf;
        logic        pass;
        logic [2:0]  idx;
        logic [23:0] tag;
    } vec_t;

    localparam logic [64:0] TOP_ALL = 65'h1_0000_0000_0000_0000;
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 64'h100C, 2'd2, 64'h1000, 65'h1010, 1'b0, 1'b1, 3'd0, "R1"},
        '{1'b0, 64'h100E, 2'd2, 64'h1000, 65'h1010, 1'b0, 1'b0, 3'd2, "R1"},
        '{1'b0, 64'h0FFF, 2'd0, 64'h1000, 65'h1010, 1'b0, 1'b0, 3'd0, "R1"},
        '{1'b0, 64'h100F, 2'd0, 64'h1000, 65'h1010, 1'b0, 1'b1, 3'd0, "R8"},
        '{1'b0, 64'h100F, 2'd1, 64'h1000, 65'h1010, 1'b0, 1'b0, 3'd1, "R8"},
        '{1'b0, 64'h1008, 2'd3, 64'h1000, 65'h1010, 1'b0, 1'b1, 3'd0, "R8"},
        '{1'b1, 64'hDEAD_BEEF_8000_0000, 2'd0, 64'hFFFF_FFFF_8000_0000,
          65'h0_FFFF_FFFF_8000_0010, 1'b0, 1'b1, 3'd0, "R2"},
        '{1'b0, 64'hDEAD_BEEF_8000_0000, 2'd0, 64'hFFFF_FFFF_8000_0000,
          65'h0_FFFF_FFFF_8000_0010, 1'b0, 1'b0, 3'd0, "R3"},
        '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 64'hFFFF_FFFF_FFFF_FFF0,
          TOP_ALL, 1'b0, 1'b0, 3'd1, "R3"},
        '{1'b0, 64'h7FFF_FFFE, 2'd2, 64'h0, TOP_ALL, 1'b0, 1'b1, 3'd0, "R3"},
        '{1'b1, 64'h7FFF_FFFE, 2'd2, 64'h0, TOP_ALL, 1'b0, 1'b0, 3'd2, "R4"},
        '{1'b1, 64'hFFFF_FFFD, 2'd2, 64'h0, TOP_ALL, 1'b0, 1'b0, 3'd3, "R5"},
        '{1'b1, 64'h7FFF_FFFE, 2'd2, 64'h0, TOP_ALL, 1'b1, 1'b1, 3'd0, "R6"},
        '{1'b1, 64'hFFFF_FFFE, 2'd3, 64'h5000, 65'h5000, 1'b1, 1'b1, 3'd0, "R6"},
        '{1'b0, 64'h2000, 2'd0, 64'h2000, 65'h2000, 1'b0, 1'b0, 3'd0, "R10"}
    };

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [1:0] exp_cause;
        @(negedge clk);
        req_valid = 1'b1; narrow_mode = v.nm; req_addr = v.addr; req_size = v.size;
        cap_base = v.base; cap_top = v.top; cap_infinite = v.inf;
        @(negedge clk);
        req_valid = 1'b0;
        exp_cause = v.pass ? 2'd0 : 2'd1;
        check(rsp_valid == 1'b1, $sformatf("%s", v.tag), "valid", 64'(rsp_valid), 64'd1);
        check(rsp_pass == v.pass, $sformatf("%s", v.tag), "pass",
              64'(rsp_pass), 64'(v.pass));
        check(rsp_cause == exp_cause && rsp_fail_idx == v.idx,
              $sformatf("%s/R7", v.tag), "cause,idx",
              {rsp_cause, 59'd0, rsp_fail_idx}, {exp_cause, 59'd0, v.idx});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog R9: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state while held in reset.
        check(!rsp_valid && !rsp_pass && rsp_cause == 2'd0 && rsp_fail_idx == 3'd0,
              "R9", "reset outputs", {rsp_valid, rsp_pass, rsp_cause, rsp_fail_idx}, 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        // R9: idle cycle after a request gives rsp_valid low.
        @(negedge clk);
        check(rsp_valid == 1'b0, "R9", "idle valid", 64'(rsp_valid), 64'd0);
        // R9: back-to-back requests, one cycle each.
        @(negedge clk);
        req_valid = 1'b1; narrow_mode = 1'b0; req_size = 2'd0;
        cap_base = 64'h1000; cap_top = 65'h1010; cap_infinite = 1'b0;
        req_addr = 64'h1004;
        @(negedge clk);
        check(rsp_valid && rsp_pass, "R9", "first of pair", 64'(rsp_pass), 64'd1);
        req_addr = 64'h1010;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid && !rsp_pass && rsp_fail_idx == 3'd0, "R9", "second of pair",
              64'(rsp_pass), 64'd0);
        // R2: upper address bits ignored in narrow mode.
        @(negedge clk);
        req_valid = 1'b1; narrow_mode = 1'b1; req_size = 2'd1;
        req_addr = 64'h1234_5678_0000_1000;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_pass == 1'b1, "R2", "upper bits ignored", 64'(rsp_pass), 64'd1);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule